// File: doc/BRIEF.md
# Windowed Command and Interrupt Status Controller

This block is the host-facing control port of a network adapter. The host writes 16-bit command words, one per cycle, qualified by a write strobe. Each word holds an opcode in the top five bits and an argument in the lower eleven. The block keeps the selected register window and a set of latched event bits. It also holds an interrupt mask, which picks the events that raise the interrupt, and a visibility mask, which picks the events that show in the status word. The receiver and transmitter enable flags live here too.

Hardware event sources raise event bits with single-cycle pulses. The host clears them with an acknowledge command whose argument is a bitmask. Reset-type commands start a fixed busy period, counted in cycles. During that period the status word shows a command-in-progress flag, and every command written is dropped. The command port is a plain write strobe with no back-pressure. The host reads the busy flag before it writes, and the block never stalls the writer. The status word is combinational from registered state, so it can be read at any time.

Top module: `cmd_status_ctrl`

## Requirements
- R1: A command is accepted only in a cycle where `cmd_valid` is 1 and the busy flag is 0. The opcode is `cmd_word[15:11]` and the argument is `cmd_word[10:0]`. Argument bits that an opcode does not use have no effect.
- R2: Opcode 1 loads the window number from argument bits 2:0. `status_word[15:13]` always shows the current window, which is 0 after reset.
- R3: `status_word[7:0]` is the event register ANDed bitwise with the visibility mask. Bit 12 is the busy flag, and bits 11:8 read 0. Opcode 15 loads the visibility mask from argument bits 7:0, and the mask is 0 after reset.
- R4: A pulse on `ev_pulse[k]` (k = 1..7) sets event bit k. `ev_pulse[0]` is ignored. Opcode 12 sets event bit 6 (interrupt requested).
- R5: Opcode 13 clears each event bit whose argument bit (7:0) is 1. An event pulse in the same cycle as the acknowledge of that bit leaves the bit set.
- R6: Opcode 14 loads the interrupt mask from argument bits 7:0. Event bit 0 (the latch) sets when an event bit among 7:1 that is enabled in the interrupt mask goes from 0 to 1. It clears only through an acknowledge with argument bit 0 set. `irq` equals the latch.
- R7: Opcodes 4 and 3 set and clear `rx_enabled`. Opcodes 9 and 10 set and clear `tx_enabled`. Both flags are 0 after reset.
- R8: Opcodes 5 and 11 pulse `rx_path_rst` and `tx_path_rst` high for exactly one cycle. They set the busy flag for `BUSY_CYCLES` cycles.
- R9: Opcode 0 clears the events, latch, masks, window and both enable flags. It sets the busy flag for `BUSY_CYCLES` cycles.
- R10: A command written while the busy flag is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_word | input | 16 | Opcode [15:11], argument [10:0] |
| ev_pulse | input | 8 | Event pulses; bit k raises event bit k, bit 0 unused |
| status_word | output | 16 | Window, busy flag, visible event bits |
| irq | output | 1 | Interrupt, follows the latch bit |
| rx_enabled | output | 1 | Receiver enable |
| tx_enabled | output | 1 | Transmitter enable |
| rx_path_rst | output | 1 | One-cycle receive-path reset |
| tx_path_rst | output | 1 | One-cycle transmit-path reset |

## Verification
The bench collides an event pulse with the acknowledge of the same bit. A design that lets the clear win would lose that event and miss the interrupt. It counts the busy samples after each reset-type command and writes a window change in the middle of the busy period. An off-by-one timer shows up as a wrong count, and a design without the busy gate moves the window. After a global reset it raises an event to show that both masks and the latch were cleared. It also fills unused argument bits and masks the interrupt-requested bit, so that a decoder reading too many bits, or a status word ignoring the visibility mask, gives a different word.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int CMD_W = 16;
  localparam int OPC_W = 5;
  localparam int ARG_W = CMD_W - OPC_W;
  localparam int EV_W  = 8;
  localparam int WIN_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_GLOBAL_RST = 5'd0,
    OP_WIN_SEL    = 5'd1,
    OP_RX_OFF     = 5'd3,
    OP_RX_ON      = 5'd4,
    OP_RX_RST     = 5'd5,
    OP_TX_ON      = 5'd9,
    OP_TX_OFF     = 5'd10,
    OP_TX_RST     = 5'd11,
    OP_REQ_INT    = 5'd12,
    OP_ACK        = 5'd13,
    OP_SET_IMASK  = 5'd14,
    OP_SET_VMASK  = 5'd15
  } opcode_e;

  typedef struct packed {
    logic            glob;
    logic            win_sel;
    logic            rx_on;
    logic            rx_off;
    logic            rx_rst;
    logic            tx_on;
    logic            tx_off;
    logic            tx_rst;
    logic            req_int;
    logic            ack;
    logic            set_imask;
    logic            set_vmask;
    logic [EV_W-1:0] arg_lo;
  } dec_t;
endpackage

// File: rtl/csc_decode.sv
module csc_decode
  import csc_pkg::*;
(
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             busy,
  output dec_t             dec,
  output logic             start_busy
);
  logic    accept;
  opcode_e opc;
  logic    unused_hi;

  assign accept    = cmd_valid && !busy;
  assign opc       = opcode_e'(cmd_word[CMD_W-1:ARG_W]);
  assign unused_hi = ^cmd_word[ARG_W-1:EV_W];

  always_comb begin
    dec        = '0;
    dec.arg_lo = cmd_word[EV_W-1:0];
    if (accept) begin
      unique case (opc)
        OP_GLOBAL_RST: dec.glob      = 1'b1;
        OP_WIN_SEL:    dec.win_sel   = 1'b1;
        OP_RX_OFF:     dec.rx_off    = 1'b1;
        OP_RX_ON:      dec.rx_on     = 1'b1;
        OP_RX_RST:     dec.rx_rst    = 1'b1;
        OP_TX_ON:      dec.tx_on     = 1'b1;
        OP_TX_OFF:     dec.tx_off    = 1'b1;
        OP_TX_RST:     dec.tx_rst    = 1'b1;
        OP_REQ_INT:    dec.req_int   = 1'b1;
        OP_ACK:        dec.ack       = 1'b1;
        OP_SET_IMASK:  dec.set_imask = 1'b1;
        OP_SET_VMASK:  dec.set_vmask = 1'b1;
        default:       ;
      endcase
    end
  end

  assign start_busy = dec.glob || dec.rx_rst || dec.tx_rst;
endmodule

// File: rtl/csc_busy_timer.sv
module csc_busy_timer #(
  parameter int BUSY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= LOAD;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != 0);

  // R8 / R9: a reset-type command raises the flag on the next cycle
  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/csc_event_bank.sv
module csc_event_bank
  import csc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev_pulse,
  input  dec_t            dec,
  output logic [EV_W-1:0] ev_vis,
  output logic            latch
);
  logic [EV_W-1:0] ev_q, imask_q, vmask_q;
  logic [EV_W-1:0] set_bits, ack_bits, fresh, ev_d;
  logic            latch_d;

  always_comb begin
    set_bits    = {ev_pulse[EV_W-1:1], 1'b0};
    set_bits[6] = set_bits[6] | dec.req_int;
    ack_bits    = dec.ack ? dec.arg_lo : '0;
    fresh       = set_bits & ~ev_q;
    latch_d     = (ev_q[0] & ~ack_bits[0]) | (|(fresh[EV_W-1:1] & imask_q[EV_W-1:1]));
    ev_d        = ((ev_q & ~ack_bits) | set_bits);
    ev_d[0]     = latch_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || dec.glob) begin
      ev_q    <= '0;
      imask_q <= '0;
      vmask_q <= '0;
    end else begin
      ev_q <= ev_d;
      if (dec.set_imask) imask_q <= dec.arg_lo;
      if (dec.set_vmask) vmask_q <= dec.arg_lo;
    end
  end

  assign ev_vis = ev_q & vmask_q;
  assign latch  = ev_q[0];

  // R5: an acknowledged bit with no coinciding pulse is clear afterwards
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.ack && !dec.glob) |=>
      ((ev_q[EV_W-1:1] & $past(dec.arg_lo[EV_W-1:1] & ~set_bits[EV_W-1:1])) == '0));

  // R6: the latch holds unless acknowledged or globally reset
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q[0] && !(dec.ack && dec.arg_lo[0]) && !dec.glob) |=> ev_q[0]);

  // R9: global reset empties events and both masks
  p_glob_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec.glob |=> (ev_q == '0 && imask_q == '0 && vmask_q == '0));
endmodule

// File: rtl/cmd_status_ctrl.sv
module cmd_status_ctrl
  import csc_pkg::*;
#(
  parameter int BUSY_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_word,
  input  logic [7:0]  ev_pulse,
  output logic [15:0] status_word,
  output logic        irq,
  output logic        rx_enabled,
  output logic        tx_enabled,
  output logic        rx_path_rst,
  output logic        tx_path_rst
);
  dec_t             dec;
  logic             start_busy, busy, latch;
  logic [EV_W-1:0]  ev_vis;
  logic [WIN_W-1:0] win_q;

  csc_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .busy      (busy),
    .dec       (dec),
    .start_busy(start_busy)
  );

  csc_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start_busy),
    .busy (busy)
  );

  csc_event_bank u_ev (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_pulse(ev_pulse),
    .dec     (dec),
    .ev_vis  (ev_vis),
    .latch   (latch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || dec.glob) begin
      win_q       <= '0;
      rx_enabled  <= 1'b0;
      tx_enabled  <= 1'b0;
      rx_path_rst <= 1'b0;
      tx_path_rst <= 1'b0;
    end else begin
      if (dec.win_sel) win_q <= dec.arg_lo[WIN_W-1:0];
      if (dec.rx_on)       rx_enabled <= 1'b1;
      else if (dec.rx_off) rx_enabled <= 1'b0;
      if (dec.tx_on)       tx_enabled <= 1'b1;
      else if (dec.tx_off) tx_enabled <= 1'b0;
      rx_path_rst <= dec.rx_rst;
      tx_path_rst <= dec.tx_rst;
    end
  end

  assign status_word = {win_q, busy, 4'b0000, ev_vis};
  assign irq         = latch;

  // R10: while busy, nothing can move the window
  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(win_q));

  // R8: path reset outputs are single-cycle pulses
  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_path_rst || tx_path_rst) |=> !(rx_path_rst || tx_path_rst));
endmodule

// File: tb/sim_cmd_status_ctrl.sv
module sim_cmd_status_ctrl;
  localparam int BUSY_N = 6;
  localparam int NV     = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [7:0]  ev_pulse = '0;
  logic [15:0] status_word;
  logic        irq, rx_enabled, tx_enabled, rx_path_rst, tx_path_rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cmd_status_ctrl #(.BUSY_CYCLES(BUSY_N)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .ev_pulse(ev_pulse), .status_word(status_word), .irq(irq),
    .rx_enabled(rx_enabled), .tx_enabled(tx_enabled),
    .rx_path_rst(rx_path_rst), .tx_path_rst(tx_path_rst)
  );

  // {valid, cmd[15:0], ev[7:0], status[15:0], irq, rx, tx}
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 16'h78FF, 8'h00, 16'h0000, 3'b000}, // R3 vis mask = FF
    {1'b0, 16'h0000, 8'h10, 16'h0010, 3'b000}, // R4 rx complete
    {1'b1, 16'h7004, 8'h00, 16'h0010, 3'b000}, // R6 imask = bit2
    {1'b0, 16'h0000, 8'h04, 16'h0015, 3'b100}, // R6 latch sets
    {1'b1, 16'h6801, 8'h00, 16'h0014, 3'b000}, // R6 ack latch only
    {1'b1, 16'h6814, 8'h00, 16'h0000, 3'b000}, // R5 ack bits
    {1'b1, 16'h0805, 8'h00, 16'hA000, 3'b000}, // R2 window 5
    {1'b1, 16'h6000, 8'h00, 16'hA040, 3'b000}, // R4 request interrupt
    {1'b1, 16'h780F, 8'h00, 16'hA000, 3'b000}, // R3 bit6 hidden
    {1'b1, 16'h78FF, 8'h00, 16'hA040, 3'b000}, // R3 bit6 visible
    {1'b1, 16'h6804, 8'h04, 16'hA045, 3'b100}, // R5 pulse beats ack
    {1'b1, 16'h6845, 8'h00, 16'hA000, 3'b000}, // R5 ack all
    {1'b1, 16'h0FFA, 8'h00, 16'h4000, 3'b000}, // R1 high arg bits ignored
    {1'b1, 16'h27FF, 8'h00, 16'h4000, 3'b010}, // R7 rx on
    {1'b1, 16'h4800, 8'h00, 16'h4000, 3'b011}, // R7 tx on
    {1'b1, 16'h5000, 8'h00, 16'h4000, 3'b010}, // R7 tx off
    {1'b1, 16'h1800, 8'h00, 16'h4000, 3'b000}, // R7 rx off
    {1'b0, 16'h0803, 8'h00, 16'h4000, 3'b000}  // R1 no strobe, no effect
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] c, input logic [7:0] e);
    @(negedge clk);
    cmd_valid = v; cmd_word = c; ev_pulse = e;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0; cmd_word = '0; ev_pulse = '0;
  endtask

  task automatic count_busy(input logic [15:0] side_cmd, output int n);
    n = 0;
    while (status_word[12] && n < 100) begin
      n++;
      if (n == 1) step(1'b1, side_cmd, 8'h00);
      else        step(1'b0, 16'h0000, 8'h00);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic p1, p2;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // reset state: R2 R3 R6 R7
    chk("R3 reset status", status_word, 16'h0000);
    chk("R6 reset irq", {15'd0, irq}, 16'h0000);
    chk("R7 reset enables", {14'd0, rx_enabled, tx_enabled}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][43], VEC[i][42:27], VEC[i][26:19]);
      chk($sformatf("vec%0d status", i), status_word, VEC[i][18:3]);
      chk($sformatf("vec%0d irq/rx/tx", i), {13'd0, irq, rx_enabled, tx_enabled},
          {13'd0, VEC[i][2:0]});
    end

    // R8 rx path reset: pulse and busy length; R10 window write dropped
    step(1'b1, 16'h2800, 8'h00);
    p1 = rx_path_rst;
    chk("R8 busy after rx reset", status_word, 16'h5000);
    count_busy(16'h0806, n);
    p2 = rx_path_rst;
    chk("R8 rx_path_rst pulse", {14'd0, p1, p2}, 16'h0002);
    chk("R8 busy length", 16'(n), 16'(BUSY_N));
    chk("R10 window kept", status_word, 16'h4000);

    // R8 tx path reset
    step(1'b1, 16'h5800, 8'h00);
    p1 = tx_path_rst;
    count_busy(16'h0000, n);
    chk("R8 tx_path_rst pulse", {15'd0, p1}, 16'h0001);
    chk("R8 tx busy length", 16'(n), 16'(BUSY_N));

    // R9 global reset clears masks, latch, window, enables
    step(1'b1, 16'h70FF, 8'h00);
    step(1'b1, 16'h2000, 8'h00);
    step(1'b0, 16'h0000, 8'h80);
    chk("R6 latch on bit7", {15'd0, irq}, 16'h0001);
    step(1'b1, 16'h0000, 8'h00);
    chk("R9 status after global reset", status_word, 16'h1000);
    chk("R9 irq/rx cleared", {14'd0, irq, rx_enabled}, 16'h0000);
    count_busy(16'h0000, n);
    chk("R9 busy length", 16'(n), 16'(BUSY_N));
    step(1'b0, 16'h0000, 8'h80);
    chk("R9 vis mask cleared", status_word, 16'h0000);
    chk("R9 imask cleared", {15'd0, irq}, 16'h0000);
    step(1'b1, 16'h78FF, 8'h00);
    chk("R9 event kept, mask reloaded", status_word, 16'h0080);

    // R4 ev_pulse[0] is ignored
    step(1'b0, 16'h0000, 8'h01);
    chk("R4 ev_pulse bit0 ignored", status_word, 16'h0080);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule